// File: doc/BRIEF.md
# Path-Tagged Indirect Target Predictor

This block predicts the destination of an indirect branch the way a trace cache does. Each table entry stands for one trace line that ends in an indirect branch. An entry is keyed by two things: the line's start address, and the taken/not-taken outcomes of the conditional branches that come before the indirect branch inside that line. Two lines that begin at the same address but follow different internal paths therefore get separate entries, and each one keeps its own target. The table is set-associative, with 16 sets of 2 ways. Each entry holds one target and a 2-bit saturating confidence counter.

Fetch logic sends a lookup with a start address, a path vector and the number of meaningful path bits. One cycle later it receives a hit flag, the predicted target and the way that matched. When the branch resolves, the back end sends a resolve with the same key, the real target and an allocate flag. The resolve trains a matching entry, or installs a new one when the key misses and allocation is requested. A runtime mode input selects how a stored target is retrained. In hold mode a stored target never changes. In write mode it follows the last resolved target. In confidence mode it is replaced only after the counter has drained to zero.

Top module: `path_tgt_pred`

## Requirements
- R1: The reset input is synchronous and active high. It invalidates every entry and zeroes every counter, so every lookup after reset misses.
- R2: A lookup sampled at a rising edge drives `pr_valid` high during the following cycle, with the result. In a cycle that follows no lookup, `pr_valid`, `pr_hit`, `pr_target` and `pr_way` are all 0.
- R3: A lookup that matches no valid entry returns `pr_hit` = 0, `pr_target` = 0 and `pr_way` = 0.
- R4: The set index is address bits [3:0]. An entry matches only when the address bits above the index, the path-length field and the used path bits are all equal. Path bit i is used when i < length; higher path bits are ignored. Entries with equal addresses but different paths hold separate targets.
- R5: A resolve that misses installs a new entry when `rs_alloc` is 1, with the resolved target and the counter set to 1. When `rs_alloc` is 0, a missing resolve changes nothing. A resolve that hits never creates a second copy of the entry.
- R6: The victim for an allocation is the lowest-numbered invalid way. If both ways are valid, the victim is the way not most recently used. Each set keeps one recency bit, and only lookup hits and allocations update it.
- R7: Mode 2'b00 (and 2'b11, which behaves the same): a resolve that hits leaves both the stored target and the counter unchanged.
- R8: Mode 2'b01: a resolve that hits overwrites the stored target with the resolved target.
- R9: Mode 2'b10: a correct resolve increments the counter, saturating at 3. A wrong resolve with the counter above 0 decrements the counter and keeps the target. A wrong resolve with the counter at 0 replaces the target and sets the counter to 1.
- R10: A resolve and a lookup in the same cycle to the same set give a lookup result that already reflects that resolve's write.
- R11: On a hit, `pr_way` gives the way that holds the matching entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Retrain policy: 00/11 hold, 01 write, 10 confidence |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Lookup trace start address |
| lk_path | input | PATH_W | Lookup conditional-branch directions |
| lk_plen | input | LEN_W | Number of meaningful lookup path bits |
| rs_valid | input | 1 | Resolve request |
| rs_addr | input | ADDR_W | Resolve trace start address |
| rs_path | input | PATH_W | Resolve conditional-branch directions |
| rs_plen | input | LEN_W | Number of meaningful resolve path bits |
| rs_target | input | TGT_W | Actual indirect target |
| rs_alloc | input | 1 | Install an entry if the key misses |
| pr_valid | output | 1 | Lookup result valid |
| pr_hit | output | 1 | Lookup matched an entry |
| pr_target | output | TGT_W | Predicted target, 0 on a miss |
| pr_way | output | WAY_W | Matching way |

## Verification
Some properties are checked every cycle. The result always follows its request by exactly one cycle. Idle and miss results carry zeroes. A same-cycle allocate on the lookup's own key always produces a hit on the next cycle, and in write mode that hit returns the target just resolved. Other behaviour can only be shown by the bench's scenarios, because it depends on history that spans many cycles: counter draining and saturation, recency-based victim choice, path-bit masking, and hold mode keeping a stale target. The bench covers these with directed sequences and with a long mixed sweep against an arithmetic reference of the table.

// File: rtl/ptp_pkg.sv
package ptp_pkg;
   // Retrain policy selected at run time.
   typedef enum logic [1:0] {
      PTP_HOLD     = 2'b00,
      PTP_WRITE    = 2'b01,
      PTP_CONF     = 2'b10,
      PTP_HOLD_ALT = 2'b11
   } ptp_mode_e;
endpackage

// File: rtl/ptp_key_mask.sv
module ptp_key_mask #(
   parameter int PATH_W = 3,
   parameter int LEN_W  = 2
) (
   input  logic [PATH_W-1:0] path,
   input  logic [LEN_W-1:0]  len,
   output logic [PATH_W-1:0] kept
);
   // A path bit takes part in the key only below the stated length.
   for (genvar i = 0; i < PATH_W; i++) begin : g_bit
      assign kept[i] = path[i] & (int'(len) > i);
   end
endmodule

// File: rtl/ptp_way_match.sv
module ptp_way_match #(
   parameter int WAYS  = 2,
   parameter int TAG_W = 17,
   parameter int WAY_W = 1
) (
   input  logic [WAYS-1:0]            vld,
   input  logic [WAYS-1:0][TAG_W-1:0] tags,
   input  logic [TAG_W-1:0]           probe,
   output logic                       hit,
   output logic [WAY_W-1:0]           way
);
   logic [WAYS-1:0] hv;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hv[w] = vld[w] && (tags[w] == probe);
   end

   // The lowest matching way wins (only one can match in practice).
   always_comb begin
      hit = |hv;
      way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (hv[w]) way = WAY_W'(w);
      end
   end
endmodule

// File: rtl/ptp_victim.sv
module ptp_victim #(
   parameter int WAYS  = 2,
   parameter int WAY_W = 1
) (
   input  logic [WAYS-1:0]  vld,
   input  logic [WAY_W-1:0] lru,
   output logic [WAY_W-1:0] victim
);
   // An empty way is used first; otherwise the recency bit decides.
   always_comb begin
      victim = lru;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!vld[w]) victim = WAY_W'(w);
      end
   end
endmodule

// File: rtl/ptp_policy.sv
module ptp_policy
   import ptp_pkg::*;
#(
   parameter int TGT_W = 16,
   parameter int CNT_W = 2
) (
   input  ptp_mode_e         mode,
   input  logic [TGT_W-1:0]  old_tgt,
   input  logic [CNT_W-1:0]  old_cnt,
   input  logic [TGT_W-1:0]  act_tgt,
   output logic [TGT_W-1:0]  new_tgt,
   output logic [CNT_W-1:0]  new_cnt
);
   localparam logic [CNT_W-1:0] CMAX = '1;
   localparam logic [CNT_W-1:0] CONE = CNT_W'(1);

   logic same;
   assign same = (old_tgt == act_tgt);

   always_comb begin
      new_tgt = old_tgt;
      new_cnt = old_cnt;
      unique case (mode)
         PTP_WRITE: begin
            if (!same) new_tgt = act_tgt;
         end
         PTP_CONF: begin
            if (same) begin
               if (old_cnt != CMAX) new_cnt = old_cnt + CONE;
            end else if (old_cnt == '0) begin
               new_tgt = act_tgt;
               new_cnt = CONE;
            end else begin
               new_cnt = old_cnt - CONE;
            end
         end
         PTP_HOLD, PTP_HOLD_ALT: begin
         end
         default: begin
         end
      endcase
   end
endmodule

// File: rtl/path_tgt_pred.sv
module path_tgt_pred
   import ptp_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int TGT_W  = 16,
   parameter int SETS   = 16,
   parameter int WAYS   = 2,
   parameter int PATH_W = 3,
   parameter int CNT_W  = 2,
   localparam int IDX_W = $clog2(SETS),
   localparam int LEN_W = $clog2(PATH_W + 1),
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
   localparam int TAG_W = ADDR_W - IDX_W + PATH_W + LEN_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        mode,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_addr,
   input  logic [PATH_W-1:0] lk_path,
   input  logic [LEN_W-1:0]  lk_plen,
   input  logic              rs_valid,
   input  logic [ADDR_W-1:0] rs_addr,
   input  logic [PATH_W-1:0] rs_path,
   input  logic [LEN_W-1:0]  rs_plen,
   input  logic [TGT_W-1:0]  rs_target,
   input  logic              rs_alloc,
   output logic              pr_valid,
   output logic              pr_hit,
   output logic [TGT_W-1:0]  pr_target,
   output logic [WAY_W-1:0]  pr_way
);
   localparam logic [CNT_W-1:0] ALLOC_CNT = CNT_W'(1);

   // Elaboration-time parameter checks.
   if ((1 << IDX_W) != SETS) begin : g_bad_sets
      $error("SETS must be a power of two");
   end
   if (WAYS != 2) begin : g_bad_ways
      $error("one recency bit per set supports exactly two ways");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("ADDR_W must exceed the index width");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("counter needs at least two bits");
   end

   // Table storage.
   logic [SETS-1:0][WAYS-1:0]             vld_q;
   logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
   logic [SETS-1:0][WAYS-1:0][TGT_W-1:0]  tgt_q;
   logic [SETS-1:0][WAYS-1:0][CNT_W-1:0]  cnt_q;
   logic [SETS-1:0][WAY_W-1:0]            lru_q;
   logic [SETS-1:0][WAY_W-1:0]            lru_d;

   ptp_mode_e mode_e;
   assign mode_e = ptp_mode_e'(mode);

   // Key formation.
   logic [PATH_W-1:0] rs_pk, lk_pk;
   logic [IDX_W-1:0]  rs_set, lk_set;
   logic [TAG_W-1:0]  rs_tag, lk_tag;

   ptp_key_mask #(.PATH_W(PATH_W), .LEN_W(LEN_W)) u_rs_key (
      .path(rs_path), .len(rs_plen), .kept(rs_pk));
   ptp_key_mask #(.PATH_W(PATH_W), .LEN_W(LEN_W)) u_lk_key (
      .path(lk_path), .len(lk_plen), .kept(lk_pk));

   assign rs_set = rs_addr[IDX_W-1:0];
   assign lk_set = lk_addr[IDX_W-1:0];
   assign rs_tag = {rs_addr[ADDR_W-1:IDX_W], rs_pk, rs_plen};
   assign lk_tag = {lk_addr[ADDR_W-1:IDX_W], lk_pk, lk_plen};

   // Resolve side: read the addressed set.
   logic [WAYS-1:0]            rs_vld_row;
   logic [WAYS-1:0][TAG_W-1:0] rs_tag_row;
   logic [WAYS-1:0][TGT_W-1:0] rs_tgt_row;
   logic [WAYS-1:0][CNT_W-1:0] rs_cnt_row;
   logic                       rs_hit;
   logic [WAY_W-1:0]           rs_way;
   logic [WAY_W-1:0]           rs_vict;
   logic [TGT_W-1:0]           pol_tgt;
   logic [CNT_W-1:0]           pol_cnt;
   logic                       rs_install;

   assign rs_vld_row = vld_q[rs_set];
   assign rs_tag_row = tag_q[rs_set];
   assign rs_tgt_row = tgt_q[rs_set];
   assign rs_cnt_row = cnt_q[rs_set];

   ptp_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_rs_match (
      .vld(rs_vld_row), .tags(rs_tag_row), .probe(rs_tag),
      .hit(rs_hit), .way(rs_way));

   ptp_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_vict (
      .vld(rs_vld_row), .lru(lru_q[rs_set]), .victim(rs_vict));

   ptp_policy #(.TGT_W(TGT_W), .CNT_W(CNT_W)) u_policy (
      .mode(mode_e), .old_tgt(rs_tgt_row[rs_way]), .old_cnt(rs_cnt_row[rs_way]),
      .act_tgt(rs_target), .new_tgt(pol_tgt), .new_cnt(pol_cnt));

   assign rs_install = rs_valid && !rs_hit && rs_alloc;

   // Post-resolve image of the resolved set.
   logic [WAYS-1:0]            nx_vld_row;
   logic [WAYS-1:0][TAG_W-1:0] nx_tag_row;
   logic [WAYS-1:0][TGT_W-1:0] nx_tgt_row;
   logic [WAYS-1:0][CNT_W-1:0] nx_cnt_row;

   always_comb begin
      nx_vld_row = rs_vld_row;
      nx_tag_row = rs_tag_row;
      nx_tgt_row = rs_tgt_row;
      nx_cnt_row = rs_cnt_row;
      for (int w = 0; w < WAYS; w++) begin
         if (rs_hit && (rs_way == WAY_W'(w))) begin
            nx_tgt_row[w] = pol_tgt;
            nx_cnt_row[w] = pol_cnt;
         end else if (!rs_hit && rs_alloc && (rs_vict == WAY_W'(w))) begin
            nx_vld_row[w] = 1'b1;
            nx_tag_row[w] = rs_tag;
            nx_tgt_row[w] = rs_target;
            nx_cnt_row[w] = ALLOC_CNT;
         end
      end
   end

   // Lookup side: forward the same-cycle resolve when the sets agree.
   logic                       fwd;
   logic [WAYS-1:0]            lk_vld_row;
   logic [WAYS-1:0][TAG_W-1:0] lk_tag_row;
   logic [WAYS-1:0][TGT_W-1:0] lk_tgt_row;
   logic                       lk_hit;
   logic [WAY_W-1:0]           lk_way;

   assign fwd        = rs_valid && (rs_set == lk_set);
   assign lk_vld_row = fwd ? nx_vld_row : vld_q[lk_set];
   assign lk_tag_row = fwd ? nx_tag_row : tag_q[lk_set];
   assign lk_tgt_row = fwd ? nx_tgt_row : tgt_q[lk_set];

   ptp_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_lk_match (
      .vld(lk_vld_row), .tags(lk_tag_row), .probe(lk_tag),
      .hit(lk_hit), .way(lk_way));

   // Recency: allocations first, then a lookup hit takes precedence.
   always_comb begin
      lru_d = lru_q;
      for (int s = 0; s < SETS; s++) begin
         if (rs_install && (rs_set == IDX_W'(s))) lru_d[s] = ~rs_vict;
         if (lk_valid && lk_hit && (lk_set == IDX_W'(s))) lru_d[s] = ~lk_way;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q     <= '0;
         tag_q     <= '0;
         tgt_q     <= '0;
         cnt_q     <= '0;
         lru_q     <= '0;
         pr_valid  <= 1'b0;
         pr_hit    <= 1'b0;
         pr_target <= '0;
         pr_way    <= '0;
      end else begin
         if (rs_valid) begin
            vld_q[rs_set] <= nx_vld_row;
            tag_q[rs_set] <= nx_tag_row;
            tgt_q[rs_set] <= nx_tgt_row;
            cnt_q[rs_set] <= nx_cnt_row;
         end
         lru_q     <= lru_d;
         pr_valid  <= lk_valid;
         pr_hit    <= lk_valid && lk_hit;
         pr_target <= (lk_valid && lk_hit) ? lk_tgt_row[lk_way] : '0;
         pr_way    <= (lk_valid && lk_hit) ? lk_way : '0;
      end
   end
endmodule

// File: rtl/ptp_chk.sv
module ptp_chk #(
   parameter int ADDR_W = 16,
   parameter int TGT_W  = 16,
   parameter int PATH_W = 3,
   parameter int LEN_W  = 2,
   parameter int WAY_W  = 1
) (
   input logic              clk,
   input logic              rst,
   input logic [1:0]        mode,
   input logic              lk_valid,
   input logic [ADDR_W-1:0] lk_addr,
   input logic [PATH_W-1:0] lk_path,
   input logic [LEN_W-1:0]  lk_plen,
   input logic              rs_valid,
   input logic [ADDR_W-1:0] rs_addr,
   input logic [PATH_W-1:0] rs_path,
   input logic [LEN_W-1:0]  rs_plen,
   input logic [TGT_W-1:0]  rs_target,
   input logic              rs_alloc,
   input logic              pr_valid,
   input logic              pr_hit,
   input logic [TGT_W-1:0]  pr_target,
   input logic [WAY_W-1:0]  pr_way
);
   logic same_key;
   assign same_key = (lk_addr == rs_addr) && (lk_path == rs_path) && (lk_plen == rs_plen);

   AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !pr_valid); // R1
   AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      lk_valid |=> pr_valid); // R2
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
      !lk_valid |=> !pr_valid); // R2
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !pr_valid |-> (!pr_hit && pr_target == '0 && pr_way == '0)); // R2
   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
      (pr_valid && !pr_hit) |-> (pr_target == '0 && pr_way == '0)); // R3
   AST_FWD_INSTALL: assert property (@(posedge clk) disable iff (rst)
      (lk_valid && rs_valid && rs_alloc && same_key) |=> pr_hit); // R10
   AST_FWD_WRITE: assert property (@(posedge clk) disable iff (rst)
      (lk_valid && rs_valid && rs_alloc && same_key && mode == 2'b01)
      |=> (pr_target == $past(rs_target))); // R8
endmodule

bind path_tgt_pred ptp_chk #(
   .ADDR_W(ADDR_W), .TGT_W(TGT_W), .PATH_W(PATH_W), .LEN_W(LEN_W), .WAY_W(WAY_W)
) u_chk (
   .clk(clk), .rst(rst), .mode(mode),
   .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_path(lk_path), .lk_plen(lk_plen),
   .rs_valid(rs_valid), .rs_addr(rs_addr), .rs_path(rs_path), .rs_plen(rs_plen),
   .rs_target(rs_target), .rs_alloc(rs_alloc),
   .pr_valid(pr_valid), .pr_hit(pr_hit), .pr_target(pr_target), .pr_way(pr_way)
);

// File: tb/sim_path_tgt_pred.sv
module sim_path_tgt_pred;
   localparam int AW = 16;
   localparam int TW = 16;

   logic          clk = 1'b0;
   logic          rst;
   logic [1:0]    mode;
   logic          lk_valid, rs_valid, rs_alloc;
   logic [AW-1:0] lk_addr, rs_addr;
   logic [2:0]    lk_path, rs_path;
   logic [1:0]    lk_plen, rs_plen;
   logic [TW-1:0] rs_target;
   logic          pr_valid, pr_hit, pr_way;
   logic [TW-1:0] pr_target;

   always #10 clk = ~clk;

   path_tgt_pred u0 (
      .clk(clk), .rst(rst), .mode(mode),
      .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_path(lk_path), .lk_plen(lk_plen),
      .rs_valid(rs_valid), .rs_addr(rs_addr), .rs_path(rs_path), .rs_plen(rs_plen),
      .rs_target(rs_target), .rs_alloc(rs_alloc),
      .pr_valid(pr_valid), .pr_hit(pr_hit), .pr_target(pr_target), .pr_way(pr_way));

   int checks = 0;
   int errors = 0;

   // Reference table built from the requirements.
   bit            mval [16][2];
   logic [AW-1:0] maddr[16][2];
   logic [4:0]    mkey [16][2];
   logic [TW-1:0] mtgt [16][2];
   int            mcnt [16][2];
   int            mlru [16];

   function automatic logic [4:0] keyof(logic [2:0] p, logic [1:0] l);
      logic [2:0] k;
      for (int i = 0; i < 3; i++) k[i] = p[i] & (int'(l) > i);
      return {l, k};
   endfunction

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int s = 0; s < 16; s++) begin
         mlru[s] = 0;
         for (int w = 0; w < 2; w++) begin
            mval[s][w] = 0; maddr[s][w] = '0; mkey[s][w] = '0;
            mtgt[s][w] = '0; mcnt[s][w] = 0;
         end
      end
   endtask

   function automatic int model_find(logic [AW-1:0] a, logic [4:0] k);
      int s = int'(a[3:0]);
      for (int w = 0; w < 2; w++)
         if (mval[s][w] && maddr[s][w] == a && mkey[s][w] == k) return w;
      return -1;
   endfunction

   task automatic model_resolve(logic [AW-1:0] a, logic [2:0] p, logic [1:0] l,
                                logic [TW-1:0] t, logic al);
      int s = int'(a[3:0]);
      logic [4:0] k = keyof(p, l);
      int w = model_find(a, k);
      if (w >= 0) begin
         if (mode == 2'b01) mtgt[s][w] = t;
         else if (mode == 2'b10) begin
            if (mtgt[s][w] == t) begin
               if (mcnt[s][w] < 3) mcnt[s][w]++;
            end else if (mcnt[s][w] == 0) begin
               mtgt[s][w] = t; mcnt[s][w] = 1;
            end else mcnt[s][w]--;
         end
      end else if (al) begin
         int v = !mval[s][0] ? 0 : (!mval[s][1] ? 1 : mlru[s]);
         mval[s][v] = 1; maddr[s][v] = a; mkey[s][v] = k;
         mtgt[s][v] = t; mcnt[s][v] = 1; mlru[s] = 1 - v;
      end
   endtask

   // One cycle: drive at a falling edge, check at the next falling edge.
   task automatic step(logic lv, logic [AW-1:0] la, logic [2:0] lp, logic [1:0] ll,
                       logic rv, logic [AW-1:0] ra, logic [2:0] rp, logic [1:0] rl,
                       logic [TW-1:0] rt, logic ral, string req);
      logic eh; logic [TW-1:0] et; logic ew;
      lk_valid = lv; lk_addr = la; lk_path = lp; lk_plen = ll;
      rs_valid = rv; rs_addr = ra; rs_path = rp; rs_plen = rl;
      rs_target = rt; rs_alloc = ral;
      if (rv) model_resolve(ra, rp, rl, rt, ral);
      eh = 0; et = '0; ew = 0;
      if (lv) begin
         int w = model_find(la, keyof(lp, ll));
         if (w >= 0) begin
            eh = 1; et = mtgt[int'(la[3:0])][w]; ew = w[0];
            mlru[int'(la[3:0])] = 1 - w;
         end
      end
      @(negedge clk);
      check(req, "pr_valid", 32'(pr_valid), 32'(lv));
      check(req, "pr_hit", 32'(pr_hit), 32'(eh));
      check(req, "pr_target", 32'(pr_target), 32'(et));
      check(req, "pr_way", 32'(pr_way), 32'(ew));
   endtask

   task automatic look(logic [AW-1:0] a, logic [2:0] p, logic [1:0] l, string req);
      step(1, a, p, l, 0, '0, '0, '0, '0, 0, req);
   endtask

   task automatic res(logic [AW-1:0] a, logic [2:0] p, logic [1:0] l,
                      logic [TW-1:0] t, logic al, string req);
      step(0, '0, '0, '0, 1, a, p, l, t, al, req);
   endtask

   task automatic do_reset();
      rst = 1; lk_valid = 0; rs_valid = 0; rs_alloc = 0;
      repeat (2) @(negedge clk);
      model_clear();
      check("R1", "pr_valid in reset", 32'(pr_valid), 0);
      rst = 0;
   endtask

   initial begin
      #(20 * 200000);
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] lcg;
      mode = 2'b00; lk_addr = '0; rs_addr = '0; lk_path = '0; rs_path = '0;
      lk_plen = '0; rs_plen = '0; rs_target = '0;
      do_reset();

      // R1 R3: every set empty after reset.
      for (int s = 0; s < 16; s++) look(AW'(s), 3'b000, 2'd0, "R1");
      step(0, '0, '0, '0, 0, '0, '0, '0, '0, 0, "R2");

      // R4: same address, two paths, two targets; unused path bits ignored.
      res(16'h0127, 3'b010, 2'd2, 16'h1111, 1, "R5");
      res(16'h0127, 3'b011, 2'd2, 16'h2222, 1, "R4");
      look(16'h0127, 3'b010, 2'd2, "R4");
      check("R4", "path A target", 32'(pr_target), 32'h1111);
      look(16'h0127, 3'b111, 2'd2, "R11");
      check("R4", "path B target", 32'(pr_target), 32'h2222);
      check("R11", "path B way", 32'(pr_way), 1);
      look(16'h0127, 3'b110, 2'd2, "R4");
      look(16'h0127, 3'b010, 2'd3, "R4");
      check("R4", "length differs", 32'(pr_hit), 0);
      look(16'h0227, 3'b010, 2'd2, "R4");

      // R5: miss without allocation does nothing.
      res(16'h0039, 3'b001, 2'd1, 16'h3333, 0, "R5");
      look(16'h0039, 3'b001, 2'd1, "R5");
      check("R5", "no install", 32'(pr_hit), 0);

      // R6: recency-based victim.
      res(16'h1005, 3'b000, 2'd0, 16'h00A0, 1, "R6");
      res(16'h2005, 3'b000, 2'd0, 16'h00B0, 1, "R6");
      look(16'h1005, 3'b000, 2'd0, "R6");
      res(16'h3005, 3'b000, 2'd0, 16'h00C0, 1, "R6");
      look(16'h2005, 3'b000, 2'd0, "R6");
      check("R6", "lru victim evicted", 32'(pr_hit), 0);
      look(16'h1005, 3'b000, 2'd0, "R6");
      look(16'h3005, 3'b000, 2'd0, "R6");
      check("R6", "new entry way", 32'(pr_way), 1);

      // R7: hold modes keep a stale target.
      mode = 2'b00;
      res(16'h1005, 3'b000, 2'd0, 16'h0F0F, 1, "R7");
      look(16'h1005, 3'b000, 2'd0, "R7");
      check("R7", "hold target", 32'(pr_target), 32'h00A0);
      mode = 2'b11;
      res(16'h1005, 3'b000, 2'd0, 16'h0F0F, 0, "R7");
      look(16'h1005, 3'b000, 2'd0, "R7");

      // R8: write mode follows the last target.
      mode = 2'b01;
      res(16'h1005, 3'b000, 2'd0, 16'h0F0F, 0, "R8");
      look(16'h1005, 3'b000, 2'd0, "R8");
      check("R8", "written target", 32'(pr_target), 32'h0F0F);

      // R9: confidence counter sequence.
      mode = 2'b10;
      res(16'h0123, 3'b001, 2'd1, 16'h000A, 1, "R9");
      res(16'h0123, 3'b001, 2'd1, 16'h000B, 0, "R9");
      look(16'h0123, 3'b001, 2'd1, "R9");
      check("R9", "kept at cnt 1", 32'(pr_target), 32'h000A);
      res(16'h0123, 3'b001, 2'd1, 16'h000B, 0, "R9");
      look(16'h0123, 3'b001, 2'd1, "R9");
      check("R9", "replaced at cnt 0", 32'(pr_target), 32'h000B);
      for (int i = 0; i < 4; i++) res(16'h0123, 3'b001, 2'd1, 16'h000B, 0, "R9");
      for (int i = 0; i < 3; i++) res(16'h0123, 3'b001, 2'd1, 16'h000C, 0, "R9");
      look(16'h0123, 3'b001, 2'd1, "R9");
      check("R9", "saturated kept", 32'(pr_target), 32'h000B);
      res(16'h0123, 3'b001, 2'd1, 16'h000C, 0, "R9");
      look(16'h0123, 3'b001, 2'd1, "R9");
      check("R9", "drained replaced", 32'(pr_target), 32'h000C);

      // R10: same-cycle forwarding.
      mode = 2'b01;
      step(1, 16'h004E, 3'b101, 2'd3, 1, 16'h004E, 3'b101, 2'd3, 16'h7777, 1, "R10");
      check("R10", "forwarded install", 32'(pr_target), 32'h7777);
      step(1, 16'h004E, 3'b101, 2'd3, 1, 16'h004E, 3'b101, 2'd3, 16'h8888, 0, "R10");
      check("R10", "forwarded write", 32'(pr_target), 32'h8888);

      // R1: reset mid-run empties the table.
      do_reset();
      look(16'h004E, 3'b101, 2'd3, "R1");
      check("R1", "entry gone", 32'(pr_hit), 0);

      // Mixed sweep over modes, keys and collisions.
      lcg = 32'h1234_5678;
      for (int c = 0; c < 6000; c++) begin
         logic [31:0] r1, r2;
         logic [AW-1:0] la, ra;
         logic [2:0] lp, rp;
         logic [1:0] ll, rl;
         if (c % 600 == 0) mode = 2'((c / 600) % 4);
         lcg = lcg * 32'd1664525 + 32'd1013904223; r1 = lcg;
         lcg = lcg * 32'd1664525 + 32'd1013904223; r2 = lcg;
         ra = {12'(r1[9:8] % 3), 2'b00, r1[3:2]};
         rp = r1[14:12]; rl = r1[17:16];
         la = {12'(r2[9:8] % 3), 2'b00, r2[3:2]};
         lp = r2[14:12]; ll = r2[17:16];
         if (r2[20]) begin la = ra; lp = rp; ll = rl; end
         step(r2[24], la, lp, ll, r1[24], ra, rp, rl, TW'(r1[27:26]),
              r1[28] | r1[29], "R9");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule